// File: doc/BRIEF.md
# Shared-Bus Register Datapath

This block is the datapath half of a small processor in which all registers meet on one internal bus. It holds eight general registers, a program counter, an instruction register, an operand latch Y, a result latch Z, a memory address register and a memory data register. Each cycle an external sequencer presents one flat control word. That word says which single source drives the bus and which registers capture it at the next clock edge. It also selects the ALU operation and the ALU input-A source, and it raises the memory strobes.

The ALU takes input A from either Y or the constant 4, and input B always from the bus. Its result can only be kept in Z. A result therefore reaches its destination one cycle later, when Z drives the bus. The memory data register has a bus side and a memory side. Memory accesses finish when the memory raises its completion flag. A cycle that waits on that flag, while the flag is low, performs no register loads, so the sequencer simply repeats the cycle until the flag rises.

Top module: `sbus_datapath`

## Requirements
- R1: After reset every register (general registers, PC, IR, Y, Z, MAR, MDR) holds zero.
- R2: The bus carries the value of the one source whose drive bit is set: general register i at ctl bit i, PC at bit 16, IR at bit 18, Z at bit 20, MDR at bit 24. With no drive bit set the bus reads zero, and `bus_mon` shows the bus.
- R3: A register captures the bus at the clock edge when its load bit is set: general register i at bit 8+i, PC at bit 17, IR at bit 19, Y at bit 22. `ir_word` shows IR.
- R4: ALU input A is the constant 4 when ctl bit 28 is set and Y otherwise. Input B is the bus. Z captures the ALU result when bit 21 is set.
- R5: ctl bits 31:29 pick the ALU operation: 0 add A+B, 1 subtract A-B (modulo 2^32), 2 AND, 3 OR, 4 XOR, 5 pass A, 6 pass B, 7 zero.
- R6: Y-from-R1, then R2 on the bus with add into Z, then Z into R3, leaves R1+R2 in R3 after three cycles.
- R7: MAR captures the bus when bit 23 is set. `mem_addr` always shows MAR.
- R8: MDR loads `mem_rdata` when bit 26 is set, and loads the bus when bit 25 is set. If both bits are set, the memory data wins. `mem_wdata` always shows MDR, and `mem_wdata_en` equals bit 27.
- R9: `mem_rd` equals ctl bit 32 and `mem_wr` equals bit 33 in the same cycle.
- R10: When ctl bit 34 (wait for completion) is set and `mem_mfc` is low, no register changes at that edge. The strobes stay as driven.
- R11: At most one drive bit is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl | input | 35 | Flat control word (layout in R2 to R10) |
| mem_rdata | input | 32 | Data from memory |
| mem_mfc | input | 1 | Memory function complete |
| mem_addr | output | 32 | Address lines, from MAR |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 32 | MDR contents toward memory |
| mem_wdata_en | output | 1 | MDR drives memory data lines |
| ir_word | output | 32 | Instruction register, for the decoder |
| bus_mon | output | 32 | Current internal bus value |

## Verification
On every cycle the assertions check four things: that at most one bus source is enabled, and that a stalled cycle leaves MAR, MDR and IR unchanged. They also check that MAR and MDR capture the bus or the memory data at the edge after their load bits, and that the constant-4 add lands in Z. The bench runs a behavioural model of every register and compares all outputs on every clock. That is the only place where the following show: the three-cycle add, each ALU operation (including the subtract wrap), the MDR load priority, and a stall repeated over several cycles that then completes.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4,
      OP_PSA  = 3'd5,
      OP_PSB  = 3'd6,
      OP_ZERO = 3'd7
   } alu_op_e;

   // control word offsets above the 2*NREG general-register bits
   localparam int unsigned K_PC_DRV   = 0;
   localparam int unsigned K_PC_LD    = 1;
   localparam int unsigned K_IR_DRV   = 2;
   localparam int unsigned K_IR_LD    = 3;
   localparam int unsigned K_Z_DRV    = 4;
   localparam int unsigned K_Z_LD     = 5;
   localparam int unsigned K_Y_LD     = 6;
   localparam int unsigned K_MAR_LD   = 7;
   localparam int unsigned K_MDR_DRV  = 8;
   localparam int unsigned K_MDR_LDB  = 9;
   localparam int unsigned K_MDR_LDM  = 10;
   localparam int unsigned K_MDR_DRM  = 11;
   localparam int unsigned K_SEL4     = 12;
   localparam int unsigned K_FN       = 13;
   localparam int unsigned K_RD       = 16;
   localparam int unsigned K_WR       = 17;
   localparam int unsigned K_WAIT     = 18;
   localparam int unsigned K_FIXED_W  = 19;
endpackage

// File: rtl/sbus_reg.sv
module sbus_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
   import sbus_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] r
);
   always_comb begin
      unique case (op)
         OP_ADD:  r = a + b;
         OP_SUB:  r = a - b;
         OP_AND:  r = a & b;
         OP_OR:   r = a | b;
         OP_XOR:  r = a ^ b;
         OP_PSA:  r = a;
         OP_PSB:  r = b;
         default: r = '0;
      endcase
   end
endmodule

// File: rtl/sbus_bus_join.sv
module sbus_bus_join #(
   parameter int unsigned W = 32,
   parameter int unsigned N = 4
) (
   input  logic [N*W-1:0] srcs,
   input  logic [N-1:0]   en,
   output logic [W-1:0]   bus
);
   always_comb begin
      bus = '0;
      for (int i = 0; i < N; i++) begin
         if (en[i]) bus = bus | srcs[i*W +: W];
      end
   end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
   import sbus_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned NREG  = 8,
   parameter int unsigned CTL_W = 2*NREG + K_FIXED_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] ctl,
   input  logic [DW-1:0]    mem_rdata,
   input  logic             mem_mfc,
   output logic [DW-1:0]    mem_addr,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic [DW-1:0]    mem_wdata,
   output logic             mem_wdata_en,
   output logic [DW-1:0]    ir_word,
   output logic [DW-1:0]    bus_mon
);
   localparam int unsigned B    = 2*NREG;
   localparam int unsigned NSRC = NREG + 4;

   if (DW < 8) begin : g_bad_dw
      $error("sbus_datapath: DW must be at least 8");
   end
   if (NREG < 2) begin : g_bad_nreg
      $error("sbus_datapath: NREG must be at least 2");
   end
   if (CTL_W != 2*NREG + K_FIXED_W) begin : g_bad_ctl
      $error("sbus_datapath: CTL_W must follow NREG");
   end

   logic [NREG-1:0] gpr_drv, gpr_ld;
   logic            ok, stall;
   logic [DW-1:0]   bus, y_q, z_q, pc_q, alu_a, alu_r, mdr_d;
   logic [NREG*DW-1:0] gpr_flat;
   logic [NSRC-1:0]    drv_vec;

   assign gpr_drv = ctl[NREG-1:0];
   assign gpr_ld  = ctl[2*NREG-1:NREG];
   assign stall   = ctl[B+K_WAIT] & ~mem_mfc;
   assign ok      = ~stall;

   // general register file, one bus-loaded register per entry
   for (genvar g = 0; g < NREG; g++) begin : g_gpr
      sbus_reg #(.W(DW)) u_r (
         .clk(clk), .rst_n(rst_n), .ld(gpr_ld[g] & ok), .d(bus),
         .q(gpr_flat[g*DW +: DW]));
   end

   sbus_reg #(.W(DW)) u_pc  (.clk(clk), .rst_n(rst_n), .ld(ctl[B+K_PC_LD] & ok),
                             .d(bus), .q(pc_q));
   sbus_reg #(.W(DW)) u_ir  (.clk(clk), .rst_n(rst_n), .ld(ctl[B+K_IR_LD] & ok),
                             .d(bus), .q(ir_word));
   sbus_reg #(.W(DW)) u_y   (.clk(clk), .rst_n(rst_n), .ld(ctl[B+K_Y_LD] & ok),
                             .d(bus), .q(y_q));
   sbus_reg #(.W(DW)) u_z   (.clk(clk), .rst_n(rst_n), .ld(ctl[B+K_Z_LD] & ok),
                             .d(alu_r), .q(z_q));
   sbus_reg #(.W(DW)) u_mar (.clk(clk), .rst_n(rst_n), .ld(ctl[B+K_MAR_LD] & ok),
                             .d(bus), .q(mem_addr));

   // memory side has priority over bus side
   assign mdr_d = ctl[B+K_MDR_LDM] ? mem_rdata : bus;
   sbus_reg #(.W(DW)) u_mdr (.clk(clk), .rst_n(rst_n),
                             .ld((ctl[B+K_MDR_LDM] | ctl[B+K_MDR_LDB]) & ok),
                             .d(mdr_d), .q(mem_wdata));

   assign drv_vec = {ctl[B+K_MDR_DRV], ctl[B+K_Z_DRV], ctl[B+K_IR_DRV],
                     ctl[B+K_PC_DRV], gpr_drv};

   sbus_bus_join #(.W(DW), .N(NSRC)) u_bus (
      .srcs({mem_wdata, z_q, ir_word, pc_q, gpr_flat}),
      .en(drv_vec), .bus(bus));

   assign alu_a = ctl[B+K_SEL4] ? DW'(4) : y_q;

   sbus_alu #(.W(DW)) u_alu (
      .a(alu_a), .b(bus), .op(alu_op_e'(ctl[B+K_FN +: 3])), .r(alu_r));

   assign mem_rd       = ctl[B+K_RD];
   assign mem_wr       = ctl[B+K_WR];
   assign mem_wdata_en = ctl[B+K_MDR_DRM];
   assign bus_mon      = bus;

   // R11: single bus driver
   assert_one_driver_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drv_vec));

   // R10: stalled cycle changes nothing observable
   assert_stall_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(mem_addr) && $stable(mem_wdata) && $stable(ir_word)));

   // R7: MAR captures the bus
   assert_mar_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[B+K_MAR_LD] && !stall) |=> (mem_addr == $past(bus)));

   // R8: memory-side load of MDR
   assert_mdr_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[B+K_MDR_LDM] && !stall) |=> (mem_wdata == $past(mem_rdata)));

   // R4: constant-4 increment reaches Z
   assert_inc4_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[B+K_Z_LD] && ctl[B+K_SEL4] && ctl[B+K_FN +: 3] == 3'd0 && !stall)
      |=> (z_q == $past(bus) + DW'(4)));
endmodule

// File: tb/sbus_datapath_tb.sv
module sbus_datapath_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [34:0] ctl = '0;
   logic [31:0] mem_rdata = '0;
   logic        mem_mfc = 1'b0;
   logic [31:0] mem_addr, mem_wdata, ir_word, bus_mon;
   logic        mem_rd, mem_wr, mem_wdata_en;

   sbus_datapath dut_i (
      .clk(clk), .rst_n(rst_n), .ctl(ctl), .mem_rdata(mem_rdata),
      .mem_mfc(mem_mfc), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_wdata_en(mem_wdata_en),
      .ir_word(ir_word), .bus_mon(bus_mon));

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   // behavioural reference state
   logic [31:0] m_gpr [8];
   logic [31:0] m_pc, m_ir, m_y, m_z, m_mar, m_mdr;

   function automatic logic [34:0] m(input int i);
      return 35'd1 << i;
   endfunction

   function automatic logic [34:0] fn(input int f);
      return 35'(f) << 29;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input string tag, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic go(input logic [34:0] v, input logic [31:0] rd,
                     input logic mf, input string tag);
      logic [31:0] e, a, r;
      logic ok;
      ctl = v; mem_rdata = rd; mem_mfc = mf;
      #1;
      e = '0;
      for (int i = 0; i < 8; i++) if (v[i]) e = e | m_gpr[i];
      if (v[16]) e = e | m_pc;
      if (v[18]) e = e | m_ir;
      if (v[20]) e = e | m_z;
      if (v[24]) e = e | m_mdr;
      chk(bus_mon, e, tag, "bus");
      chk({31'd0, mem_rd}, {31'd0, v[32]}, tag, "mem_rd R9");
      chk({31'd0, mem_wr}, {31'd0, v[33]}, tag, "mem_wr R9");
      chk({31'd0, mem_wdata_en}, {31'd0, v[27]}, tag, "wdata_en R8");
      a = v[28] ? 32'd4 : m_y;
      case (v[31:29])
         3'd0: r = a + e;
         3'd1: r = a - e;
         3'd2: r = a & e;
         3'd3: r = a | e;
         3'd4: r = a ^ e;
         3'd5: r = a;
         3'd6: r = e;
         default: r = 32'd0;
      endcase
      ok = !(v[34] && !mf);
      @(posedge clk);
      if (ok) begin
         for (int i = 0; i < 8; i++) if (v[8+i]) m_gpr[i] = e;
         if (v[17]) m_pc = e;
         if (v[19]) m_ir = e;
         if (v[21]) m_z = r;
         if (v[22]) m_y = e;
         if (v[23]) m_mar = e;
         if (v[26]) m_mdr = rd;
         else if (v[25]) m_mdr = e;
      end
      @(negedge clk);
      chk(mem_addr, m_mar, tag, "mem_addr");
      chk(mem_wdata, m_mdr, tag, "mdr");
      chk(ir_word, m_ir, tag, "ir");
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) m_gpr[i] = '0;
      m_pc = '0; m_ir = '0; m_y = '0; m_z = '0; m_mar = '0; m_mdr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      go('0, 0, 0, "R1 R2 idle after reset");
      go(m(16), 0, 0, "R1 pc reset");
      go(m(20), 0, 0, "R1 z reset");

      // fill R1, R2, R5 through MDR
      go(m(26) | m(32), 32'h0000_0013, 1, "R8 R9 mdr from memory");
      go(m(24) | m(9), 0, 0, "R3 R11 mdr to r1");
      go(m(26) | m(32), 32'h0000_0022, 1, "R8 mdr from memory");
      go(m(24) | m(10), 0, 0, "R3 mdr to r2");
      go(m(26) | m(32), 32'hF0F0_1234, 1, "R8 mdr from memory");
      go(m(24) | m(13), 0, 0, "R3 mdr to r5");

      // three-cycle add R3 = R1 + R2
      go(m(1) | m(22), 0, 0, "R6 step1 y from r1");
      go(m(2) | m(21) | fn(0), 0, 0, "R6 R4 step2 add into z");
      go(m(20) | m(11), 0, 0, "R6 step3 z to r3");
      go(m(3), 0, 0, "R6 r3 holds sum");

      // every ALU operation with Y = R1, B = R5
      for (int f = 1; f < 8; f++) begin
         go(m(5) | m(21) | fn(f), 0, 0, "R5 alu op into z");
         go(m(20), 0, 0, "R5 z result on bus");
      end

      // PC + 4 through the constant path
      go(m(16) | m(28) | m(21) | m(23) | m(32) | fn(0), 0, 0, "R4 R7 pc plus 4");
      go(m(20) | m(17), 0, 0, "R4 z to pc");
      go(m(16), 0, 0, "R4 pc advanced");

      // stalled read repeated, then completing
      for (int k = 0; k < 3; k++)
         go(m(26) | m(34) | m(22) | m(5) | m(32) | m(23), 32'hDEAD_BEEF, 0, "R10 stall");
      go(m(5) | m(21) | fn(5), 0, 0, "R10 y unchanged after stall");
      go(m(20), 0, 0, "R10 z shows y");
      go(m(26) | m(34) | m(22) | m(5) | m(32), 32'hDEAD_BEEF, 1, "R10 completion");
      go(m(24), 0, 0, "R10 mdr after completion");

      // write: MAR from R3, MDR from R5, wait on completion
      go(m(3) | m(23), 0, 0, "R7 mar from r3");
      go(m(5) | m(25) | m(33) | m(27), 0, 0, "R8 mdr from bus");
      go(m(27) | m(33) | m(34) | m(2) | m(22), 0, 0, "R10 write wait");
      go(m(27) | m(33) | m(34), 0, 1, "R10 write done");

      // both MDR loads: memory wins
      go(m(3) | m(25) | m(26), 32'hABCD_0001, 1, "R8 both loads memory wins");
      go(m(24), 0, 0, "R8 priority result");

      // IR load and drive
      go(m(24) | m(19), 0, 0, "R3 ir load");
      go(m(18) | m(22), 0, 0, "R2 ir on bus");
      go('0, 0, 0, "R2 no driver");

      finish_run();
   end
endmodule